// File: doc/BRIEF.md
# Virtual address segment decoder

This block sorts each virtual address issued by a processor's load/store path into one of three kinds: addresses that need the TLB, addresses that map straight onto physical memory, and addresses that are illegal. It works in a 32-bit addressing mode and in a 64-bit addressing mode, which is picked by a plain control pin. For directly mapped addresses it forms the physical address and the cacheability itself. For mapped addresses it raises a request on a lookup port toward an external TLB and combines the returned page frame with the page offset.

The decision on translation is combinational in the same cycle as the request. When a request fails and is not a probe, the block registers an exception one cycle later. The exception carries a cause code that tells TLB misses from address errors and loads from stores, and the faulting virtual address is held in a bad-address register. Probe requests report success or failure without touching the exception state. A load whose translation lands on an address with no backing target is flagged for zero data.

Requests enter on a valid/ready stream. The block never applies back-pressure: ready is held high, so every cycle with valid high is one accepted request. The producer needs no ready-based stall logic, and results belong to the cycle in which valid is high.

Top module: `vseg_xlate`

## Requirements
- R1: In 32-bit mode only address bits 31:0 matter. Bits 31:29 pick the segment. Values 0, 1, 2, 3, 6 and 7 are mapped and raise tlb_req. Value 4 is direct and cached. Value 5 is direct and uncached. For both direct segments the physical address is bits 28:0, zero-extended.
- R2: In 64-bit mode, bits 63:40 equal to 0x000000, 0x400000 or 0xC00000 are mapped. So are bits 63:40 equal to 0xFFFFFF with bits 39:29 equal to 0x7FE or 0x7FF.
- R3: In 64-bit mode, bits 63:40 equal to 0xFFFFFF with bits 39:29 equal to 0x7FC give direct cached access, and 0x7FD gives direct uncached access. The physical address is bits 28:0, zero-extended.
- R4: In 64-bit mode, bits 63:62 = 2'b10 with bits 58:40 all zero select the physical window. The physical address is the low PA_W bits of the address. The access is uncached when bits 61:59 equal 2 and cached otherwise.
- R5: Any other 64-bit region, and any other sub-field value under 0xFFFFFF, is an address error: xl_fault is high and xl_ok is low in the same cycle.
- R6: A mapped address with tlb_hit high translates to {tlb_pfn, low PG_W address bits}, with cacheability taken from tlb_cached. With tlb_hit low it is a fault.
- R7: A failing non-probe request raises exc_valid for exactly the next cycle. exc_cause is 2 for a TLB load miss, 3 for a TLB store miss, 4 for an address-error load and 5 for an address-error store. bad_vaddr takes the request's address.
- R8: A probe request (req_probe high) reports xl_fault but raises no exc_valid and leaves bad_vaddr unchanged.
- R9: A load that translates while tgt_undef is high raises zero_fill and no exception. A store never raises zero_fill.
- R10: After reset, exc_valid is 0, exc_cause is 0 and bad_vaddr is 0.
- R11: req_ready is always 1. While req_valid is low, tlb_req, xl_ok, xl_fault and zero_fill stay low, and no exception follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode64 | input | 1 | 1 selects 64-bit decoding, 0 selects 32-bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1 |
| req_vaddr | input | 64 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_probe | input | 1 | Lookup only, no exception |
| tlb_req | output | 1 | TLB lookup needed for this request |
| tlb_hit | input | 1 | TLB found a valid entry |
| tlb_pfn | input | PA_W-PG_W | Page frame returned by TLB |
| tlb_cached | input | 1 | Cacheability returned by TLB |
| tgt_undef | input | 1 | Physical target has no backing device |
| xl_ok | output | 1 | Translation succeeded |
| xl_fault | output | 1 | Translation failed |
| xl_paddr | output | PA_W | Physical address |
| xl_cached | output | 1 | Access is cacheable |
| zero_fill | output | 1 | Load must return zero data |
| exc_valid | output | 1 | Exception raised (one cycle) |
| exc_cause | output | 5 | Exception cause code |
| bad_vaddr | output | 64 | Last faulting virtual address |

## Verification
A wrong decode shows at the ports in the same cycle as the request. It appears as the wrong choice among tlb_req, xl_ok and xl_fault, as a wrong physical address, or as a flipped cached bit, so the sweeps over every 32-bit segment, every top address byte and every 0xFFFFFF sub-field expose it at once. A wrong exception register shows one cycle later as a missing or extra exc_valid pulse or a wrong cause. A bad_vaddr that was wrongly overwritten by a probe or a passing request persists and is caught on every later request, because its value is compared after each one.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

  typedef enum logic [1:0] {
    SEG_MAPPED  = 2'd0,
    SEG_DIRECT  = 2'd1,
    SEG_ILLEGAL = 2'd2
  } seg_kind_e;

  typedef struct packed {
    seg_kind_e   kind;
    logic        cached;
    logic [63:0] dpa;
  } seg_info_t;

  localparam logic [4:0] CAUSE_TLB_LD = 5'd2;
  localparam logic [4:0] CAUSE_TLB_ST = 5'd3;
  localparam logic [4:0] CAUSE_AE_LD  = 5'd4;
  localparam logic [4:0] CAUSE_AE_ST  = 5'd5;

  localparam logic [2:0] WIN_ATTR_UNCACHED = 3'd2;

endpackage

// File: rtl/vseg_decode32.sv
module vseg_decode32
  import vseg_pkg::*;
(
  input  logic [31:0] vaddr,
  output seg_info_t   info
);
  localparam int SEG_LSB = 29;

  logic [2:0] seg;
  assign seg = vaddr[31:SEG_LSB];

  always_comb begin
    info.kind   = SEG_MAPPED;
    info.cached = 1'b0;
    info.dpa    = {{(64-SEG_LSB){1'b0}}, vaddr[SEG_LSB-1:0]};
    case (seg)
      3'd4: begin info.kind = SEG_DIRECT; info.cached = 1'b1; end
      3'd5: begin info.kind = SEG_DIRECT; info.cached = 1'b0; end
      default: info.kind = SEG_MAPPED;
    endcase
  end
endmodule

// File: rtl/vseg_decode64.sv
module vseg_decode64
  import vseg_pkg::*;
#(
  parameter int PA_W = 36
)(
  input  logic [63:0] vaddr,
  output seg_info_t   info
);
  localparam int SUB_LSB = 29;

  logic [23:0] region;
  logic [10:0] sub;
  logic        in_window;
  logic [2:0]  attr;

  assign region    = vaddr[63:40];
  assign sub       = vaddr[39:SUB_LSB];
  assign attr      = vaddr[61:59];
  assign in_window = (region[23:22] == 2'b10) && (region[18:0] == '0);

  always_comb begin
    info.kind   = SEG_ILLEGAL;
    info.cached = 1'b0;
    info.dpa    = {{(64-SUB_LSB){1'b0}}, vaddr[SUB_LSB-1:0]};
    if (region == 24'h000000 || region == 24'h400000 || region == 24'hC00000) begin
      info.kind = SEG_MAPPED;
    end else if (region == 24'hFFFFFF) begin
      case (sub)
        11'h7FC: begin info.kind = SEG_DIRECT; info.cached = 1'b1; end
        11'h7FD: begin info.kind = SEG_DIRECT; info.cached = 1'b0; end
        11'h7FE, 11'h7FF: info.kind = SEG_MAPPED;
        default: info.kind = SEG_ILLEGAL;
      endcase
    end else if (in_window) begin
      info.kind   = SEG_DIRECT;
      info.cached = (attr != WIN_ATTR_UNCACHED);
      info.dpa    = {{(64-PA_W){1'b0}}, vaddr[PA_W-1:0]};
    end
  end
endmodule

// File: rtl/vseg_exc.sv
module vseg_exc
  import vseg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        is_miss,
  input  logic        is_store,
  input  logic [63:0] vaddr,
  output logic        exc_valid,
  output logic [4:0]  exc_cause,
  output logic [63:0] bad_vaddr
);
  logic [4:0] cause_d;

  always_comb begin
    if (is_miss) cause_d = is_store ? CAUSE_TLB_ST : CAUSE_TLB_LD;
    else         cause_d = is_store ? CAUSE_AE_ST  : CAUSE_AE_LD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_cause <= '0;
      bad_vaddr <= '0;
    end else begin
      exc_valid <= take;
      if (take) begin
        exc_cause <= cause_d;
        bad_vaddr <= vaddr;
      end
    end
  end

  // R7
  cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_cause >= CAUSE_TLB_LD && exc_cause <= CAUSE_AE_ST));

  // R7
  bad_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (bad_vaddr == $past(vaddr)));
endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
  import vseg_pkg::*;
#(
  parameter int PA_W = 36,
  parameter int PG_W = 12,
  localparam int PFN_W = PA_W - PG_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode64,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [63:0]      req_vaddr,
  input  logic             req_store,
  input  logic             req_probe,
  output logic             tlb_req,
  input  logic             tlb_hit,
  input  logic [PFN_W-1:0] tlb_pfn,
  input  logic             tlb_cached,
  input  logic             tgt_undef,
  output logic             xl_ok,
  output logic             xl_fault,
  output logic [PA_W-1:0]  xl_paddr,
  output logic             xl_cached,
  output logic             zero_fill,
  output logic             exc_valid,
  output logic [4:0]       exc_cause,
  output logic [63:0]      bad_vaddr
);
  seg_info_t info32, info64, info;
  logic is_mapped, is_illegal, miss, take;

  vseg_decode32 u_dec32 (.vaddr(req_vaddr[31:0]), .info(info32));
  vseg_decode64 #(.PA_W(PA_W)) u_dec64 (.vaddr(req_vaddr), .info(info64));

  assign info       = mode64 ? info64 : info32;
  assign is_mapped  = (info.kind == SEG_MAPPED);
  assign is_illegal = (info.kind == SEG_ILLEGAL);
  assign miss       = is_mapped && !tlb_hit;

  assign req_ready = 1'b1;
  assign tlb_req   = req_valid && is_mapped;
  assign xl_fault  = req_valid && (miss || is_illegal);
  assign xl_ok     = req_valid && !(miss || is_illegal);
  assign xl_paddr  = is_mapped ? {tlb_pfn, req_vaddr[PG_W-1:0]} : info.dpa[PA_W-1:0];
  assign xl_cached = is_mapped ? tlb_cached : info.cached;
  assign zero_fill = xl_ok && !req_store && tgt_undef;
  assign take      = xl_fault && !req_probe;

  vseg_exc u_exc (
    .clk(clk), .rst_n(rst_n), .take(take), .is_miss(miss), .is_store(req_store),
    .vaddr(req_vaddr), .exc_valid(exc_valid), .exc_cause(exc_cause), .bad_vaddr(bad_vaddr)
  );

  // R7
  exc_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xl_fault && !req_probe) |=> exc_valid);

  // R8
  probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_probe) |=> (!exc_valid && $stable(bad_vaddr)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !exc_valid);

  // R5
  ok_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_ok && xl_fault));

  // R9
  zero_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_fill |=> !exc_valid);
endmodule

// File: tb/vseg_xlate_bench.sv
module vseg_xlate_bench;
  localparam int PA_W = 36;
  localparam int PG_W = 12;
  localparam int PFN_W = PA_W - PG_W;

  logic clk = 0, rst_n = 0;
  logic mode64 = 0, req_valid = 0, req_store = 0, req_probe = 0;
  logic [63:0] req_vaddr = '0;
  logic tlb_hit = 0, tlb_cached = 0, tgt_undef = 0;
  logic [PFN_W-1:0] tlb_pfn = '0;
  logic req_ready, tlb_req, xl_ok, xl_fault, xl_cached, zero_fill, exc_valid;
  logic [PA_W-1:0] xl_paddr;
  logic [4:0] exc_cause;
  logic [63:0] bad_vaddr;

  int checks = 0, errors = 0;
  logic [63:0] exp_bad = '0;

  always #5 clk = ~clk;

  vseg_xlate #(.PA_W(PA_W), .PG_W(PG_W)) u_vseg_xlate (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store), .req_probe(req_probe), .tlb_req(tlb_req),
    .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn), .tlb_cached(tlb_cached), .tgt_undef(tgt_undef),
    .xl_ok(xl_ok), .xl_fault(xl_fault), .xl_paddr(xl_paddr), .xl_cached(xl_cached),
    .zero_fill(zero_fill), .exc_valid(exc_valid), .exc_cause(exc_cause), .bad_vaddr(bad_vaddr)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 0 mapped, 1 direct, 2 illegal
  function automatic void model(input logic m64, input logic [63:0] va,
                                output int kind, output logic cac, output logic [PA_W-1:0] pa);
    logic [23:0] rg;
    logic [10:0] sb;
    kind = 2; cac = 0; pa = PA_W'(va[28:0]);
    if (!m64) begin
      kind = (va[31:29] == 3'd4 || va[31:29] == 3'd5) ? 1 : 0;
      cac  = (va[31:29] == 3'd4);
    end else begin
      rg = va[63:40]; sb = va[39:29];
      if (rg == 24'h000000 || rg == 24'h400000 || rg == 24'hC00000) kind = 0;
      else if (rg == 24'hFFFFFF) begin
        if (sb == 11'h7FE || sb == 11'h7FF) kind = 0;
        else if (sb == 11'h7FC) begin kind = 1; cac = 1; end
        else if (sb == 11'h7FD) begin kind = 1; cac = 0; end
      end else if (va[63:62] == 2'b10 && va[58:40] == 19'd0) begin
        kind = 1; pa = va[PA_W-1:0]; cac = (va[61:59] != 3'd2);
      end
    end
  endfunction

  task automatic run(input logic m64, input logic [63:0] va, input logic st, input logic pr,
                     input logic hit, input logic undef);
    int kind; logic cac, flt, ok, zf, tk; logic [PA_W-1:0] pa; string tag;
    @(negedge clk);
    mode64 = m64; req_vaddr = va; req_store = st; req_probe = pr; tlb_hit = hit;
    tgt_undef = undef; tlb_pfn = va[47:24] ^ 24'h5A3C1F; tlb_cached = va[13];
    req_valid = 1;
    #2;
    model(m64, va, kind, cac, pa);
    if (kind == 0) begin pa = {tlb_pfn, va[PG_W-1:0]}; cac = va[13]; end
    flt = (kind == 2) || (kind == 0 && !hit);
    ok  = !flt;
    zf  = ok && !st && undef;
    tk  = flt && !pr;
    if (zf) tag = "R9";
    else if (!m64) tag = "R1";
    else if (kind == 2) tag = "R5";
    else if (kind == 0) tag = hit ? "R2" : "R6";
    else tag = (va[63:62] == 2'b10) ? "R4" : "R3";
    check(tag, {xl_ok, xl_fault, tlb_req, zero_fill, req_ready},
               {ok, flt, (kind == 0), zf, 1'b1});
    if (ok) check(tag, {xl_paddr, xl_cached}, {pa, cac});
    @(posedge clk); #1;
    if (tk) exp_bad = va;
    check(tk ? "R7" : (pr && flt ? "R8" : tag), {exc_valid, bad_vaddr}, {tk, exp_bad});
    if (tk) check("R7", exc_cause, flt && kind == 0 ? (st ? 5'd3 : 5'd2) : (st ? 5'd5 : 5'd4));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10", {exc_valid, exc_cause, bad_vaddr}, '0);
    rst_n = 1;
    @(negedge clk);

    // R11 idle: mapped missing address with valid low
    mode64 = 0; req_vaddr = 64'h0000_0000_1000_0000; tlb_hit = 0; req_valid = 0;
    #2;
    check("R11", {tlb_req, xl_ok, xl_fault, zero_fill, req_ready}, 5'b00001);
    @(posedge clk); #1;
    check("R11", exc_valid, 1'b0);

    // R1 sweep all 32-bit segments
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 16; c++)
        run(1'b0, {(c[3] ? 32'hFFFFFFFF : 32'h12345678), s[2:0], 29'h0ABCDEF1},
            c[0], c[2], c[1], c[3]);

    // R2/R4/R5 sweep every top address byte
    for (int b = 0; b < 256; b++)
      run(1'b1, {b[7:0], 16'h0, 40'h98_7654_3210 ^ 40'(b)}, b[0], b[4] & b[5], b[1], b[3]);

    // R2/R3/R5 sweep every sub-field under 0xFFFFFF
    for (int s = 0; s < 2048; s++)
      run(1'b1, {24'hFFFFFF, s[10:0], 29'h1F00_0ABC}, s[0], s[3] & s[2], s[1], s[4]);

    // R5 near-miss regions
    run(1'b1, 64'h0000_0100_0000_1000, 1'b0, 1'b0, 1'b1, 1'b0);
    run(1'b1, 64'h8001_0000_0000_1000, 1'b1, 1'b0, 1'b1, 1'b0);
    // R4 uncached window attribute and a cached one
    run(1'b1, 64'h9000_00AB_CDEF_0123, 1'b0, 1'b0, 1'b0, 1'b0);
    run(1'b1, 64'hA800_0012_3456_7890, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8 probe after a fault keeps bad_vaddr
    run(1'b0, 64'h0000_0000_0040_0000, 1'b1, 1'b0, 1'b0, 1'b0);
    run(1'b0, 64'h0000_0000_7000_0000, 1'b0, 1'b1, 1'b0, 1'b0);
    // R9 store to undefined target: no zero fill
    run(1'b1, 64'hFFFF_FFFF_A000_0040, 1'b1, 1'b0, 1'b0, 1'b1);
    run(1'b1, 64'hFFFF_FFFF_8000_0040, 1'b0, 1'b0, 1'b0, 1'b1);

    @(negedge clk); req_valid = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule